// File: doc/BRIEF.md
# Masked Packed Signed Minimum Unit

This block is a SIMD execution stage that takes two vectors of up to 512 bits and returns, lane by lane, the signed minimum of the paired elements. The lanes are 32 or 64 bits wide, and the active vector length is 128, 256 or 512 bits. A per-lane write mask can leave lanes out of the computation. A lane left out either keeps an older destination value or becomes zero. A broadcast flag makes every lane compare against the lowest element of the second operand. An operand-class select sets which widths and lengths are legal and what happens to the destination bits above the active length.

The datapath is combinational. A single output register captures its result on each accepted request. A request is accepted when `in_valid` is high, and `out_valid` follows one cycle later. Decoding, operand fetch and exception handling are done elsewhere. The caller presents the destination's previous contents on `old_dst` when merging is wanted.

Top module: `pmin_unit`

## Requirements
- R1: Each active lane returns the element of `src1` when it is strictly less than the paired element of operand two, both read as two's-complement signed values. Otherwise it returns operand two's element.
- R2: `elem64`=0 selects 32-bit lanes and `elem64`=1 selects 64-bit lanes. Lane j occupies bits [j*w +: w]. The lane count is the active length divided by the lane width.
- R3: `vlen` codes give the active length: 0 is 128 bits, 1 is 256 bits, and 2 or 3 is 512 bits.
- R4: With `cls` = 2 or 3 and `mask_en`=1, mask bit j governs lane j. A clear bit makes that lane copy `old_dst` when `zero_mode`=0, or write zero when `zero_mode`=1. Mask bits at or beyond the lane count have no effect. When `mask_en`=0, or in any other class, every active lane is computed.
- R5: With `cls` = 2 or 3 and `bcast`=1, every lane compares against the lowest element of `src2` (bits [31:0] or [63:0], by lane width). In the other classes `bcast` has no effect.
- R6: With `cls`=0 (two-operand class), the unit uses 32-bit lanes over 128 bits whatever `elem64`, `vlen`, `mask_en` and `bcast` say. `result[511:128]` equals `src1[511:128]`.
- R7: With `cls`=1 (three-operand unmasked class), the unit uses 32-bit lanes. A `vlen` of 512 is treated as 256, and the mask is ignored. For `cls` = 1, 2 and 3, every result bit above the active length is zero.
- R8: The result appears one clock after a cycle with `in_valid` high, and `out_valid` is high for exactly those cycles. While no request is accepted, `result` holds its value.
- R9: While `rst_n` is low at a clock edge, `result` is cleared to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request accepted this cycle |
| elem64 | input | 1 | Lane width: 0 = 32-bit, 1 = 64-bit |
| vlen | input | 2 | Active length code |
| cls | input | 2 | Operand class: 0 two-operand, 1 unmasked, 2/3 masked |
| mask_en | input | 1 | Write mask in use |
| zero_mode | input | 1 | Masked-off lanes: 0 merge, 1 zero |
| bcast | input | 1 | Compare every lane with the lowest element of src2 |
| kmask | input | 16 | Per-lane write mask, bit j for lane j |
| src1 | input | 512 | First operand (destination in the two-operand class) |
| src2 | input | 512 | Second operand |
| old_dst | input | 512 | Previous destination value used for merging |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 512 | Registered result |

## Verification
A wrong lane-select decode shows at the ports one cycle after the request. It appears as a lane holding the wrong source: an old destination value, a zero, or an unmasked minimum where the mask said otherwise. The error is confined to the lanes the decode covers. A wrong active-length or class decode shows up first in the upper bits, which become nonzero or lose `src1` contents, again on the very next cycle. A fault in the output register or valid flag breaks the hold-while-idle behaviour or the valid pulse immediately. The reference model compares every register bit on every clock.

// File: rtl/pmin_pkg.sv
// Shared encodings for the masked packed signed minimum unit.
// Assumes: class codes arrive on a 2-bit field; slot select codes are local.
package pmin_pkg;
    typedef enum logic [1:0] {
        CLS_LEGACY = 2'd0,
        CLS_PLAIN  = 2'd1,
        CLS_MASKED = 2'd2,
        CLS_MASKX  = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        SEL_MIN  = 2'd0,
        SEL_OLD  = 2'd1,
        SEL_ZERO = 2'd2,
        SEL_SRC1 = 2'd3
    } slot_sel_e;
endpackage

// File: rtl/pmin_ctrl.sv
// Control decode: turns class, length, width, mask and mode inputs into an
// effective lane width, an effective broadcast flag and one source select
// per 32-bit slot of the vector.
// Assumes: NSLOT is a multiple of 4 (a 128-bit length is NSLOT/4 slots).
module pmin_ctrl #(
    parameter int NSLOT = 16
) (
    input  logic                   elem64,
    input  logic [1:0]             vlen,
    input  logic [1:0]             cls,
    input  logic                   mask_en,
    input  logic                   zero_mode,
    input  logic                   bcast,
    input  logic [NSLOT-1:0]       kmask,
    output logic                   eff_e64,
    output logic                   eff_bcast,
    output logic [NSLOT-1:0][1:0]  slot_sel
);
    import pmin_pkg::*;

    localparam int CW         = $clog2(NSLOT + 1);
    localparam int BASE_WORDS = NSLOT / 4;

    logic          is_legacy;
    logic          is_plain;
    logic          is_masked;
    logic [1:0]    vl_eff;
    logic [CW-1:0] nwords;

    // Classify the operand class and clamp the length code per class.
    always_comb begin
        is_legacy = (cls == CLS_LEGACY);
        is_plain  = (cls == CLS_PLAIN);
        is_masked = cls[1];
        if (is_legacy)
            vl_eff = 2'd0;
        else if (is_plain)
            vl_eff = (vlen == 2'd0) ? 2'd0 : 2'd1;
        else
            vl_eff = (vlen == 2'd0) ? 2'd0 : ((vlen == 2'd1) ? 2'd1 : 2'd2);
        nwords    = CW'(BASE_WORDS) << vl_eff;
        eff_e64   = is_masked & elem64;
        eff_bcast = is_masked & bcast;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [CW-1:0] SIDX = CW'(s);
        logic kbit;

        // Pick the mask bit that owns this slot for the current lane width.
        always_comb kbit = eff_e64 ? kmask[s/2] : kmask[s];

        // Choose where this slot's result bits come from.
        always_comb begin
            if (SIDX >= nwords)
                slot_sel[s] = is_legacy ? SEL_SRC1 : SEL_ZERO;
            else if (is_masked && mask_en && !kbit)
                slot_sel[s] = zero_mode ? SEL_ZERO : SEL_OLD;
            else
                slot_sel[s] = SEL_MIN;
        end
    end
endmodule

// File: rtl/pmin_pair.sv
// One 64-bit datapath column: two 32-bit signed minimums or one 64-bit
// signed minimum, with broadcast of operand two's lowest element.
// Assumes: the caller supplies the lowest word and doubleword of operand two.
module pmin_pair #(
    parameter int WORD_W = 32
) (
    input  logic [2*WORD_W-1:0] a,
    input  logic [2*WORD_W-1:0] b_lane,
    input  logic [WORD_W-1:0]   b_word0,
    input  logic [2*WORD_W-1:0] b_dw0,
    input  logic                e64,
    input  logic                bc,
    output logic [2*WORD_W-1:0] min_o
);
    localparam int DW = 2 * WORD_W;

    logic [WORD_W-1:0] b_lo, b_hi, m_lo, m_hi;
    logic [DW-1:0]     b_wide, m_wide;

    // Select operand two per granule, replacing it with element 0 on broadcast.
    always_comb begin
        b_lo   = bc ? b_word0 : b_lane[WORD_W-1:0];
        b_hi   = bc ? b_word0 : b_lane[DW-1:WORD_W];
        b_wide = bc ? b_dw0   : b_lane;
    end

    // Signed compare at both granularities; first operand wins only if strictly lower.
    always_comb begin
        m_lo   = ($signed(a[WORD_W-1:0]) < $signed(b_lo)) ? a[WORD_W-1:0] : b_lo;
        m_hi   = ($signed(a[DW-1:WORD_W]) < $signed(b_hi)) ? a[DW-1:WORD_W] : b_hi;
        m_wide = ($signed(a) < $signed(b_wide)) ? a : b_wide;
        min_o  = e64 ? m_wide : {m_hi, m_lo};
    end
endmodule

// File: rtl/pmin_select.sv
// Output slot multiplexer: per 32-bit slot, chooses the lane minimum, the
// old destination, zero, or the first operand, as decoded by the control.
// Assumes: slot_sel codes follow pmin_pkg::slot_sel_e.
module pmin_select #(
    parameter int NSLOT  = 16,
    parameter int WORD_W = 32
) (
    input  logic [NSLOT*WORD_W-1:0] min_v,
    input  logic [NSLOT*WORD_W-1:0] old_dst,
    input  logic [NSLOT*WORD_W-1:0] src1,
    input  logic [NSLOT-1:0][1:0]   slot_sel,
    output logic [NSLOT*WORD_W-1:0] res
);
    import pmin_pkg::*;

    for (genvar s = 0; s < NSLOT; s++) begin : g_mux
        // Route one slot according to its decoded select.
        always_comb begin
            case (slot_sel_e'(slot_sel[s]))
                SEL_MIN:  res[s*WORD_W +: WORD_W] = min_v[s*WORD_W +: WORD_W];
                SEL_OLD:  res[s*WORD_W +: WORD_W] = old_dst[s*WORD_W +: WORD_W];
                SEL_SRC1: res[s*WORD_W +: WORD_W] = src1[s*WORD_W +: WORD_W];
                default:  res[s*WORD_W +: WORD_W] = '0;
            endcase
        end
    end
endmodule

// File: rtl/pmin_unit.sv
// Masked packed signed minimum unit, top level. Combinational lane array
// followed by one result register behind a valid flag.
// Assumes: DATA_W is a multiple of 4*WORD_W and at least 256 bits; the
// mask carries one bit per narrow lane.
module pmin_unit #(
    parameter int DATA_W = 512,
    parameter int WORD_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       elem64,
    input  logic [1:0]                 vlen,
    input  logic [1:0]                 cls,
    input  logic                       mask_en,
    input  logic                       zero_mode,
    input  logic                       bcast,
    input  logic [DATA_W/WORD_W-1:0]   kmask,
    input  logic [DATA_W-1:0]          src1,
    input  logic [DATA_W-1:0]          src2,
    input  logic [DATA_W-1:0]          old_dst,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          result
);
    localparam int NSLOT = DATA_W / WORD_W;
    localparam int NPAIR = NSLOT / 2;
    localparam int DW    = 2 * WORD_W;

    logic                  eff_e64;
    logic                  eff_bcast;
    logic [NSLOT-1:0][1:0] slot_sel;
    logic [DATA_W-1:0]     min_v;
    logic [DATA_W-1:0]     res_c;

    pmin_ctrl #(.NSLOT(NSLOT)) u_ctrl (
        .elem64    (elem64),
        .vlen      (vlen),
        .cls       (cls),
        .mask_en   (mask_en),
        .zero_mode (zero_mode),
        .bcast     (bcast),
        .kmask     (kmask),
        .eff_e64   (eff_e64),
        .eff_bcast (eff_bcast),
        .slot_sel  (slot_sel)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        pmin_pair #(.WORD_W(WORD_W)) u_pair (
            .a       (src1[p*DW +: DW]),
            .b_lane  (src2[p*DW +: DW]),
            .b_word0 (src2[WORD_W-1:0]),
            .b_dw0   (src2[DW-1:0]),
            .e64     (eff_e64),
            .bc      (eff_bcast),
            .min_o   (min_v[p*DW +: DW])
        );
    end

    pmin_select #(.NSLOT(NSLOT), .WORD_W(WORD_W)) u_sel (
        .min_v    (min_v),
        .old_dst  (old_dst),
        .src1     (src1),
        .slot_sel (slot_sel),
        .res      (res_c)
    );

    // Capture the result on an accepted request; valid follows the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= res_c;
        end
    end
endmodule

// File: rtl/pmin_unit_chk.sv
// Property checker for pmin_unit, attached by bind below.
// Assumes: DATA_W >= 256.
module pmin_unit_chk #(
    parameter int DATA_W = 512,
    parameter int WORD_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [1:0]               vlen,
    input logic [1:0]               cls,
    input logic                     mask_en,
    input logic                     zero_mode,
    input logic [DATA_W/WORD_W-1:0] kmask,
    input logic [DATA_W-1:0]        src1,
    input logic [DATA_W-1:0]        src2,
    input logic                     out_valid,
    input logic [DATA_W-1:0]        result
);
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    a_r6_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == 2'd0) |=> result[DATA_W-1:128] == $past(src1[DATA_W-1:128]));

    a_r7_zero_above_128: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls != 2'd0 && vlen == 2'd0) |=> result[DATA_W-1:128] == '0);

    a_r7_plain_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == 2'd1) |=> result[DATA_W-1:256] == '0);

    a_r4_zero_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls[1] && mask_en && zero_mode && !kmask[0]) |=> result[WORD_W-1:0] == '0);

    a_r1_lane0_min: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == 2'd1) |=>
            ($signed(result[WORD_W-1:0]) <= $signed($past(src1[WORD_W-1:0])) &&
             $signed(result[WORD_W-1:0]) <= $signed($past(src2[WORD_W-1:0]))));
endmodule

bind pmin_unit pmin_unit_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .vlen      (vlen),
    .cls       (cls),
    .mask_en   (mask_en),
    .zero_mode (zero_mode),
    .kmask     (kmask),
    .src1      (src1),
    .src2      (src2),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/pmin_unit_test.sv
// Self-checking bench: a behavioural per-clock reference model of the
// register contents, compared against the ports at every falling edge.
module pmin_unit_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         elem64;
    logic [1:0]   vlen;
    logic [1:0]   cls;
    logic         mask_en;
    logic         zero_mode;
    logic         bcast;
    logic [15:0]  kmask;
    logic [511:0] src1, src2, old_dst;
    logic         out_valid;
    logic [511:0] result;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_tag  = "R1";

    logic         m_valid;
    logic [511:0] m_res;
    string        m_tag;

    always #5 clk = ~clk;

    pmin_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem64(elem64),
        .vlen(vlen), .cls(cls), .mask_en(mask_en), .zero_mode(zero_mode),
        .bcast(bcast), .kmask(kmask), .src1(src1), .src2(src2),
        .old_dst(old_dst), .out_valid(out_valid), .result(result)
    );

    function automatic logic [511:0] ref_min(
        input logic e64_in, input logic [1:0] vl, input logic [1:0] c,
        input logic men, input logic zm, input logic bc_in,
        input logic [15:0] k, input logic [511:0] s1, input logic [511:0] s2,
        input logic [511:0] od);
        logic [511:0] r;
        logic [63:0]  ae, be, oe, val;
        longint       av, bv;
        int           words, n;
        logic         e64, bc, legacy, plain, masked;
        legacy = (c == 2'd0);
        plain  = (c == 2'd1);
        masked = c[1];
        if (legacy)          words = 4;
        else if (vl == 2'd0) words = 4;
        else if (vl == 2'd1) words = 8;
        else                 words = 16;
        if (plain && words == 16) words = 8;
        e64 = masked && e64_in;
        bc  = masked && bc_in;
        n   = e64 ? words / 2 : words;
        r   = legacy ? s1 : '0;
        for (int j = 0; j < n; j++) begin
            if (e64) begin
                ae = s1[j*64 +: 64];
                be = bc ? s2[63:0] : s2[j*64 +: 64];
                oe = od[j*64 +: 64];
            end else begin
                ae = {{32{s1[j*32+31]}}, s1[j*32 +: 32]};
                be = bc ? {{32{s2[31]}}, s2[31:0]} : {{32{s2[j*32+31]}}, s2[j*32 +: 32]};
                oe = {32'd0, od[j*32 +: 32]};
            end
            av = ae;
            bv = be;
            if (masked && men && !k[j]) val = zm ? 64'd0 : oe;
            else                        val = (av < bv) ? ae : be;
            if (e64) r[j*64 +: 64] = val;
            else     r[j*32 +: 32] = val[31:0];
        end
        return r;
    endfunction

    // Reference register model, updated on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_res   <= '0;
            m_tag   <= "R9";
        end else if (in_valid) begin
            m_valid <= 1'b1;
            m_res   <= ref_min(elem64, vlen, cls, mask_en, zero_mode, bcast,
                               kmask, src1, src2, old_dst);
            m_tag   <= cur_tag;
        end else begin
            m_valid <= 1'b0;
            m_tag   <= "R8";
        end
    end

    task automatic check_now();
        n_checks++;
        if (out_valid !== m_valid || result !== m_res) begin
            n_fail++;
            $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                     m_tag, out_valid, result, m_valid, m_res);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check_now();
    endtask

    task automatic idle();
        in_valid = 1'b0;
        step();
    endtask

    task automatic op(input string tag, input logic e, input logic [1:0] vl,
                      input logic [1:0] c, input logic me, input logic zm,
                      input logic bc, input logic [15:0] k);
        cur_tag = tag;
        in_valid = 1'b1; elem64 = e; vlen = vl; cls = c;
        mask_en = me; zero_mode = zm; bcast = bc; kmask = k;
        step();
    endtask

    function automatic logic [31:0] pick_word();
        case ($urandom_range(0, 5))
            0: return 32'h8000_0000;
            1: return 32'h7fff_ffff;
            2: return 32'h0000_0000;
            3: return 32'hffff_ffff;
            default: return $urandom;
        endcase
    endfunction

    task automatic fill_random();
        for (int w = 0; w < 16; w++) begin
            src1[w*32 +: 32]    = pick_word();
            src2[w*32 +: 32]    = ($urandom_range(0, 3) == 0) ? src1[w*32 +: 32] : pick_word();
            old_dst[w*32 +: 32] = $urandom;
        end
        if ($urandom_range(0, 3) == 0) begin
            for (int q = 0; q < 8; q++) begin
                src1[q*64 +: 64] = ($urandom_range(0, 1) == 0) ? 64'h8000_0000_0000_0000
                                                               : 64'h7fff_ffff_ffff_ffff;
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; elem64 = 1'b0; vlen = 2'd0; cls = 2'd1;
        mask_en = 1'b0; zero_mode = 1'b0; bcast = 1'b0; kmask = '0;
        src1 = '1; src2 = '1; old_dst = '1;
        repeat (2) @(negedge clk);
        // R9: reset state at the ports
        n_checks++;
        if (out_valid !== 1'b0 || result !== '0) begin
            n_fail++;
            $display("FAIL R9: valid=%0b result=%h expected valid=0 result=0", out_valid, result);
        end
        rst_n = 1'b1;

        // R1: explicit lane values, -5 vs 3 and 7 vs -2, plain class 128 bits
        fill_random();
        src1[31:0] = 32'hffff_fffb; src2[31:0] = 32'h0000_0003;
        src1[63:32] = 32'h0000_0007; src2[63:32] = 32'hffff_fffe;
        op("R1", 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0);
        n_checks++;
        if (result[63:0] !== 64'hffff_fffe_ffff_fffb) begin
            n_fail++;
            $display("FAIL R1: result=%h expected=%h", result[63:0], 64'hffff_fffe_ffff_fffb);
        end

        // R2: 64-bit lanes at full length, then 32-bit lanes
        fill_random(); op("R2", 1'b1, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0);
        fill_random(); op("R2", 1'b0, 2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 16'h0);
        // R3: every length code, including code 3
        for (int v = 0; v < 4; v++) begin
            fill_random(); op("R3", 1'b0, v[1:0], 2'd3, 1'b0, 1'b0, 1'b0, 16'h0);
            fill_random(); op("R3", 1'b1, v[1:0], 2'd2, 1'b0, 1'b0, 1'b0, 16'h0);
        end
        // R4: merge and zero masking; bits above the lane count set to test they do nothing
        fill_random(); op("R4", 1'b0, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 16'hff5a);
        fill_random(); op("R4", 1'b0, 2'd1, 2'd2, 1'b1, 1'b1, 1'b0, 16'hff5a);
        fill_random(); op("R4", 1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 16'hfffe);
        fill_random(); op("R4", 1'b1, 2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 16'h0036);
        fill_random(); op("R4", 1'b0, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 16'h0000);
        // R5: broadcast in the masked class, and ignored in the plain class
        fill_random(); op("R5", 1'b0, 2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 16'h0);
        fill_random(); op("R5", 1'b1, 2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 16'h00a5);
        fill_random(); op("R5", 1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 16'h0);
        // R6: two-operand class ignores width, length, mask and broadcast
        fill_random(); op("R6", 1'b1, 2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 16'h0000);
        // R7: plain class clamps 512 to 256 and ignores the mask
        fill_random(); op("R7", 1'b1, 2'd2, 2'd1, 1'b1, 1'b1, 1'b0, 16'h0000);
        fill_random(); op("R7", 1'b0, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0);
        // R8: idle cycles hold the result while inputs change
        fill_random(); idle(); fill_random(); idle();
        // R9: reset in the middle of traffic
        fill_random(); in_valid = 1'b1; rst_n = 1'b0; cur_tag = "R9"; step();
        rst_n = 1'b1;

        for (int i = 0; i < 600; i++) begin
            fill_random();
            if ($urandom_range(0, 7) == 0) idle();
            else op("R1", 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom), 16'($urandom));
        end
        idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule